// File: doc/BRIEF.md
# Store-Direct Control Sequencer

This block is the control sequencer for one instruction of a small 16-bit bus-based datapath. The instruction writes a register to memory at an address formed from the program counter. A start strobe arrives with the instruction word and the current PC. If the opcode field marks a store, the block captures both values. It then steps through three control cycles and returns to idle.

In each cycle the sequencer drives the datapath control lines as one set: the two address-mux selects, the MAR-source select, the two bus gates, the MAR and MDR load enables, the register-read select, the ALU operation, the memory enable and the read/write line. All of these lines appear at the ports.

A behavioural datapath is included so that the effect of the instruction can be seen. It has an offset adder, an eight-entry register file, the ALU, the internal bus, MAR, MDR and a word memory. A preload port writes the register file, and a combinational peek port reads the memory. The instruction never writes the PC.

Top module: `st_store_unit`

## Requirements
- R1: The target address is the captured PC plus instruction bits [8:0] sign-extended to 16 bits, with 16-bit wraparound. The memory word written is the one indexed by the low MEM_AW bits of that address.
- R2: The word stored equals the register-file entry selected by instruction bits [11:9].
- R3: The first cycle after an accepted start (the address cycle) drives a fixed set: addr2_sel=2 (9-bit offset), addr1_sel=0 (PC), marmux_sel=0 (adder), gate_marmux=1 and ld_mar=1. Every other control is 0, and bus_val carries the target address.
- R4: The second cycle (the data cycle) drives sr1_sel=0 (bits [11:9]), alu_op=3 (pass A), gate_alu=1, mio_en=0 and ld_mdr=1. Every other control is 0, and bus_val carries the source register.
- R5: The third cycle (the write cycle) drives mio_en=1 and r_w=1 (write). Neither bus gate nor either load enable is active.
- R6: A MAR or MDR load shows on mar_q or mdr_q only from the cycle after the load. mar_q holds the target address in the data cycle, and mdr_q holds the source register in the write cycle.
- R7: busy is high for exactly three cycles per instruction. done is high only in the write cycle. After that cycle the block is idle, with busy=0.
- R8: At most one bus gate is active in any cycle. While idle, every control output is 0 and bus_val is 0.
- R9: A start while busy has no effect. IR and PC are captured at acceptance, so input changes during a run do not alter that run.
- R10: A start whose instruction bits [15:12] differ from 4'b0011 is not accepted, and busy stays 0.
- R11: During reset busy, done and all controls are 0, and the register file reads 0.
- R12: Memory words other than the target address are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, sampled while idle |
| ir | input | 16 | Instruction word |
| pc | input | 16 | Program counter value |
| rf_we | input | 1 | Register-file preload write enable |
| rf_widx | input | 3 | Preload register index |
| rf_wdata | input | 16 | Preload data |
| peek_addr | input | MEM_AW | Memory peek address |
| peek_data | output | 16 | Memory word at peek_addr |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | High during the write cycle |
| addr1_sel | output | 1 | 0 = PC, 1 = register to the adder |
| addr2_sel | output | 2 | 0 zero, 1 6-bit, 2 9-bit, 3 11-bit offset |
| marmux_sel | output | 1 | 0 = adder, 1 = zero-extended bits [7:0] |
| gate_marmux | output | 1 | MAR-source onto bus |
| gate_alu | output | 1 | ALU onto bus |
| ld_mar | output | 1 | MAR load |
| ld_mdr | output | 1 | MDR load |
| sr1_sel | output | 1 | 0 = bits [11:9], 1 = bits [8:6] |
| alu_op | output | 2 | 0 add, 1 and, 2 not, 3 pass A |
| mio_en | output | 1 | Memory enable; 0 makes MDR take the bus |
| r_w | output | 1 | 1 = write |
| bus_val | output | 16 | Internal bus value |
| mar_q | output | 16 | MAR contents |
| mdr_q | output | 16 | MDR contents |

## Verification
The start strobe is sampled at a rising edge, and the address-cycle controls and bus value appear in the cycle that follows. The data cycle comes one cycle later; mar_q already holds the target address there. The write cycle comes one cycle after that; mdr_q holds the source word there and done is high. The memory word and busy=0 can be seen one cycle after the write cycle. The bench drives and samples on falling edges, and each task checks each value at exactly one of these four falling edges after the strobe.

// File: rtl/st_seq_pkg.sv
package st_seq_pkg;

  localparam int XLEN = 16;
  localparam logic [3:0] OPC_STORE = 4'b0011;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_DATA  = 2'd2,
    PH_WRITE = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ALU_ADD   = 2'd0,
    ALU_AND   = 2'd1,
    ALU_NOT   = 2'd2,
    ALU_PASSA = 2'd3
  } alu_op_e;

  typedef enum logic [1:0] {
    A2_ZERO  = 2'd0,
    A2_OFF6  = 2'd1,
    A2_OFF9  = 2'd2,
    A2_OFF11 = 2'd3
  } a2_sel_e;

  typedef struct packed {
    logic    addr1_reg;
    a2_sel_e addr2;
    logic    marmux_vec;
    logic    gate_marmux;
    logic    gate_alu;
    logic    ld_mar;
    logic    ld_mdr;
    logic    sr1_alt;
    alu_op_e alu;
    logic    mio_en;
    logic    r_w;
  } ctrl_t;

  // Sign-extend the low nb bits of a word to XLEN bits.
  function automatic logic [XLEN-1:0] sext_low(input logic [XLEN-1:0] w, input int nb);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) begin
      r[i] = (i < nb) ? w[i] : w[nb-1];
    end
    return r;
  endfunction

  // PC-relative target of the store instruction.
  function automatic logic [XLEN-1:0] pc_rel_target(input logic [XLEN-1:0] pcv,
                                                     input logic [XLEN-1:0] irv);
    return pcv + sext_low(irv, 9);
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      ALU_ADD: r = a + b;
      ALU_AND: r = a & b;
      ALU_NOT: r = ~a;
      default: r = a;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/st_seq_fsm.sv
module st_seq_fsm
  import st_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   go,
  output logic   accept,
  output phase_e phase,
  output ctrl_t  ctrl,
  output logic   busy,
  output logic   done
);

  phase_e phase_nx;

  assign accept = go && (phase == PH_IDLE);

  always_comb begin
    case (phase)
      PH_IDLE:  phase_nx = accept ? PH_ADDR : PH_IDLE;
      PH_ADDR:  phase_nx = PH_DATA;
      PH_DATA:  phase_nx = PH_WRITE;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

  // One fixed control word per phase; all fields of a phase change together.
  always_comb begin
    ctrl = '0;
    case (phase)
      PH_ADDR: begin
        ctrl.addr2       = A2_OFF9;
        ctrl.addr1_reg   = 1'b0;
        ctrl.marmux_vec  = 1'b0;
        ctrl.gate_marmux = 1'b1;
        ctrl.ld_mar      = 1'b1;
      end
      PH_DATA: begin
        ctrl.sr1_alt  = 1'b0;
        ctrl.alu      = ALU_PASSA;
        ctrl.gate_alu = 1'b1;
        ctrl.mio_en   = 1'b0;
        ctrl.ld_mdr   = 1'b1;
      end
      PH_WRITE: begin
        ctrl.mio_en = 1'b1;
        ctrl.r_w    = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

  assign busy = (phase != PH_IDLE);
  assign done = (phase == PH_WRITE);

endmodule

// File: rtl/st_regfile.sv
module st_regfile #(
  parameter int NREG = 8,
  parameter int W    = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx_a,
  input  logic [IW-1:0] ridx_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    regs[g] <= '0;
      else if (we && widx == IW'(g)) regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[ridx_a];
  assign rdata_b = regs[ridx_b];

endmodule

// File: rtl/st_datapath.sv
module st_datapath
  import st_seq_pkg::*;
#(
  parameter int MEM_AW = 8,
  parameter int NREG   = 8,
  localparam int MEM_WORDS = 1 << MEM_AW,
  localparam int IW        = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic [XLEN-1:0]   ir_q,
  input  logic [XLEN-1:0]   pc_q,
  input  logic              rf_we,
  input  logic [IW-1:0]     rf_widx,
  input  logic [XLEN-1:0]   rf_wdata,
  input  logic [MEM_AW-1:0] peek_addr,
  output logic [XLEN-1:0]   peek_data,
  output logic [XLEN-1:0]   bus,
  output logic [XLEN-1:0]   mar_q,
  output logic [XLEN-1:0]   mdr_q
);

  logic [IW-1:0]   sr1_idx;
  logic [XLEN-1:0] sr1_val, sr2_val;
  logic [XLEN-1:0] a1_val, a2_val, adder_out, marmux_out, alu_out;
  logic [XLEN-1:0] mem_rd, mdr_in;
  logic [XLEN-1:0] mem [MEM_WORDS];

  assign sr1_idx = ctrl.sr1_alt ? IW'(ir_q[8:6]) : IW'(ir_q[11:9]);

  st_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .widx    (rf_widx),
    .wdata   (rf_wdata),
    .ridx_a  (sr1_idx),
    .ridx_b  (IW'(ir_q[2:0])),
    .rdata_a (sr1_val),
    .rdata_b (sr2_val)
  );

  always_comb begin
    case (ctrl.addr2)
      A2_OFF6:  a2_val = sext_low(ir_q, 6);
      A2_OFF9:  a2_val = sext_low(ir_q, 9);
      A2_OFF11: a2_val = sext_low(ir_q, 11);
      default:  a2_val = '0;
    endcase
  end

  assign a1_val     = ctrl.addr1_reg ? sr1_val : pc_q;
  assign adder_out  = a1_val + a2_val;
  assign marmux_out = ctrl.marmux_vec ? {8'h00, ir_q[7:0]} : adder_out;
  assign alu_out    = alu_eval(ctrl.alu, sr1_val, sr2_val);

  always_comb begin
    if (ctrl.gate_marmux)   bus = marmux_out;
    else if (ctrl.gate_alu) bus = alu_out;
    else                    bus = '0;
  end

  assign mem_rd = mem[mar_q[MEM_AW-1:0]];
  assign mdr_in = ctrl.mio_en ? mem_rd : bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
      mdr_q <= '0;
    end else begin
      if (ctrl.ld_mar) mar_q <= bus;
      if (ctrl.ld_mdr) mdr_q <= mdr_in;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.mio_en && ctrl.r_w) mem[mar_q[MEM_AW-1:0]] <= mdr_q;
  end

  assign peek_data = mem[peek_addr];

endmodule

// File: rtl/st_store_unit.sv
module st_store_unit
  import st_seq_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       ir,
  input  logic [15:0]       pc,
  input  logic              rf_we,
  input  logic [2:0]        rf_widx,
  input  logic [15:0]       rf_wdata,
  input  logic [MEM_AW-1:0] peek_addr,
  output logic [15:0]       peek_data,
  output logic              busy,
  output logic              done,
  output logic              addr1_sel,
  output logic [1:0]        addr2_sel,
  output logic              marmux_sel,
  output logic              gate_marmux,
  output logic              gate_alu,
  output logic              ld_mar,
  output logic              ld_mdr,
  output logic              sr1_sel,
  output logic [1:0]        alu_op,
  output logic              mio_en,
  output logic              r_w,
  output logic [15:0]       bus_val,
  output logic [15:0]       mar_q,
  output logic [15:0]       mdr_q
);

  logic        go, accept;
  phase_e      phase;
  ctrl_t       ctrl;
  logic [15:0] ir_q, pc_q;

  assign go = start && (ir[15:12] == OPC_STORE);

  st_seq_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .accept (accept),
    .phase  (phase),
    .ctrl   (ctrl),
    .busy   (busy),
    .done   (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0;
      pc_q <= '0;
    end else if (accept) begin
      ir_q <= ir;
      pc_q <= pc;
    end
  end

  st_datapath #(.MEM_AW(MEM_AW), .NREG(8)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .ir_q      (ir_q),
    .pc_q      (pc_q),
    .rf_we     (rf_we),
    .rf_widx   (rf_widx),
    .rf_wdata  (rf_wdata),
    .peek_addr (peek_addr),
    .peek_data (peek_data),
    .bus       (bus_val),
    .mar_q     (mar_q),
    .mdr_q     (mdr_q)
  );

  assign addr1_sel   = ctrl.addr1_reg;
  assign addr2_sel   = ctrl.addr2;
  assign marmux_sel  = ctrl.marmux_vec;
  assign gate_marmux = ctrl.gate_marmux;
  assign gate_alu    = ctrl.gate_alu;
  assign ld_mar      = ctrl.ld_mar;
  assign ld_mdr      = ctrl.ld_mdr;
  assign sr1_sel     = ctrl.sr1_alt;
  assign alu_op      = ctrl.alu;
  assign mio_en      = ctrl.mio_en;
  assign r_w         = ctrl.r_w;

endmodule

// File: rtl/st_store_unit_chk.sv
module st_store_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        gate_marmux,
  input logic        gate_alu,
  input logic        ld_mar,
  input logic        ld_mdr,
  input logic        mio_en,
  input logic        r_w,
  input logic [15:0] bus_val,
  input logic [15:0] mar_q,
  input logic [15:0] mdr_q,
  input logic [15:0] pc_q,
  input logic [15:0] ir_q
);
  import st_seq_pkg::*;

  assert_one_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gate_marmux, gate_alu}));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(gate_marmux || gate_alu || ld_mar || ld_mdr || mio_en || r_w));

  assert_addr_on_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mar |-> bus_val == pc_rel_target(pc_q, ir_q));

  assert_addr_then_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mar |=> ld_mdr && gate_alu && !mio_en);

  assert_data_then_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mdr |=> mio_en && r_w && done);

  assert_write_then_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mio_en && r_w) |=> !busy);

  assert_mar_next_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mar |=> mar_q == $past(bus_val));

  assert_mdr_next_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_mdr && !mio_en) |=> mdr_q == $past(bus_val));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_capture_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ld_mar) |-> $stable(pc_q) && $stable(ir_q));

endmodule

bind st_store_unit st_store_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .gate_marmux (gate_marmux),
  .gate_alu    (gate_alu),
  .ld_mar      (ld_mar),
  .ld_mdr      (ld_mdr),
  .mio_en      (mio_en),
  .r_w         (r_w),
  .bus_val     (bus_val),
  .mar_q       (mar_q),
  .mdr_q       (mdr_q),
  .pc_q        (pc_q),
  .ir_q        (ir_q)
);

// File: tb/tb_st_store_unit.sv
module tb_st_store_unit;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [15:0]   ir = '0, pc = '0;
  logic          rf_we = 1'b0;
  logic [2:0]    rf_widx = '0;
  logic [15:0]   rf_wdata = '0;
  logic [AW-1:0] peek_addr = '0;
  logic [15:0]   peek_data;
  logic          busy, done, addr1_sel, marmux_sel, gate_marmux, gate_alu;
  logic          ld_mar, ld_mdr, sr1_sel, mio_en, r_w;
  logic [1:0]    addr2_sel, alu_op;
  logic [15:0]   bus_val, mar_q, mdr_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  logic [15:0] shadow [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  st_store_unit #(.MEM_AW(AW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] target_of(input logic [15:0] p, input logic [15:0] i);
    logic signed [15:0] off;
    off = 16'($signed(i[8:0]));
    return p + off;
  endfunction

  function automatic logic [15:0] ctl_word();
    return {addr1_sel, addr2_sel, marmux_sel, gate_marmux, gate_alu, ld_mar, ld_mdr,
            sr1_sel, alu_op, mio_en, r_w, busy, done};
  endfunction

  task automatic load_reg(input int idx, input logic [15:0] v);
    @(negedge clk);
    rf_we = 1'b1; rf_widx = 3'(idx); rf_wdata = v;
    @(negedge clk);
    rf_we = 1'b0;
    shadow[idx] = v;
  endtask

  // Full store with per-cycle checks; poke_mid exercises R9.
  task automatic run_store(input logic [2:0] sr, input logic [8:0] off, input logic [15:0] p,
                           input bit poke_mid);
    logic [15:0] i, ea;
    i  = {4'b0011, sr, off};
    ea = target_of(p, i);
    @(negedge clk);
    ir = i; pc = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_mid) begin ir = {4'b0011, ~sr, ~off}; pc = ~p; start = 1'b1; end
    // R3 address cycle: addr1=0 addr2=2 marmux=0 gate_marmux ld_mar busy
    chk(ctl_word() == {1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0},
        "R3 address-cycle controls", ctl_word(), 0);
    chk(bus_val == ea, "R1 bus carries target", bus_val, ea);
    @(negedge clk);
    // R4 data cycle
    chk(ctl_word() == {1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0},
        "R4 data-cycle controls", ctl_word(), 0);
    chk(mar_q == ea, "R6 MAR visible in data cycle", mar_q, ea);
    chk(bus_val == shadow[sr], "R2 bus carries source reg", bus_val, shadow[sr]);
    @(negedge clk);
    // R5 write cycle, R7 done
    chk(ctl_word() == {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1},
        "R5 write-cycle controls", ctl_word(), 0);
    chk(mdr_q == shadow[sr], "R6 MDR visible in write cycle", mdr_q, shadow[sr]);
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !done, "R7 idle after three cycles", {busy, done}, 0);
    chk(ctl_word() == 16'h0 && bus_val == 16'h0, "R8 idle controls quiet", ctl_word(), 0);
    peek_addr = ea[AW-1:0];
    #1;
    chk(peek_data == shadow[sr], "R1 R2 stored word at target", peek_data, shadow[sr]);
    if (poke_mid) begin
      @(negedge clk);
      chk(!busy, "R9 start while busy ignored", busy, 0);
    end
  endtask

  task automatic t_reset();
    #1;
    chk(ctl_word() == 16'h0, "R11 reset controls", ctl_word(), 0);
    chk(bus_val == 16'h0 && mar_q == 16'h0 && mdr_q == 16'h0, "R11 reset datapath", bus_val, 0);
  endtask

  task automatic t_reset_regfile();
    // Store an unloaded register: R11 says it reads 0
    shadow[5] = 16'h0000;
    run_store(3'd5, 9'h010, 16'h0040, 1'b0);
  endtask

  task automatic t_bad_opcode();
    @(negedge clk);
    ir = 16'h7A05; pc = 16'h0010; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !ld_mar, "R10 other opcode not accepted", busy, 0);
  endtask

  task automatic t_neighbour();
    logic [15:0] a0;
    run_store(3'd1, 9'h020, 16'h0000, 1'b0);
    run_store(3'd2, 9'h021, 16'h0000, 1'b0);
    peek_addr = 8'h20;
    #1;
    a0 = peek_data;
    chk(a0 == shadow[1], "R12 neighbour word kept", a0, shadow[1]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) shadow[k] = '0;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset_regfile();
    load_reg(3, 16'hBEEF);
    load_reg(1, 16'h1234);
    load_reg(2, 16'h5A5A);
    load_reg(7, 16'hC001);
    run_store(3'd3, 9'h005, 16'h3000, 1'b0);  // positive offset
    run_store(3'd7, 9'h1F0, 16'h3010, 1'b0);  // negative offset
    run_store(3'd2, 9'h001, 16'hFFFF, 1'b0);  // wraparound past 16 bits
    run_store(3'd0, 9'h100, 16'h0200, 1'b0);  // most negative offset, R0
    run_store(3'd3, 9'h0FF, 16'h0050, 1'b1);  // largest offset, mid-run restart poke
    t_bad_opcode();
    t_neighbour();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule